// File: doc/BRIEF.md
# Latency-Table Issue Interlock

This block sits at the issue stage of a single-issue, five-stage pipeline that shares integer and floating-point units. All functional units are fully pipelined. Each cycle it sees the decoded class of the waiting instruction, along with its destination register and its two source registers. It holds the instruction back until every true read-after-write dependence has had enough intervening cycles. The number of cycles needed depends on both the producing class and the way the consumer uses the value, and comes from a fixed latency table.

A short history of recent producers is kept. Each entry carries a down-counter that ticks every cycle, including cycles in which the unit is stalling. A stall cycle leaves the waiting instruction in place and pushes a bubble into the history. Branches have a single delay slot: the instruction after a branch always issues, and the unit marks it with a flag. A saturating counter totals the cycles spent stalled.

Class codes on `in_cls`: 0 integer ALU, 1 double-word load, 2 FP ALU, 3 double-word store, 4 conditional branch. A store reads its address through source A and its data through source B.

Top module: `ilk_unit`

## Requirements
- R1: While reset is held, and after it, the history is empty, `stall_o` is 0, `dslot_o` is 0 and `stall_cnt_o` is 0. A producer issued before reset creates no dependence after reset.
- R2: An FP ALU result (class 2) read by another FP ALU operation needs 3 intervening cycles. Any instructions issued in between count towards the 3.
- R3: An FP ALU result read as store data (class 3, source B) needs 2 intervening cycles.
- R4: A load result (class 1) read by an FP ALU operation needs 1 intervening cycle.
- R5: A load result read as store data needs 0 intervening cycles.
- R6: An integer ALU result (class 0) read by a branch (class 4) needs 1 intervening cycle. Read by another integer operation, or as a store address (source A), it needs 0.
- R7: Registers are matched per file: source FP bit 1 selects the FP file and 0 selects the integer file. Integer register 0 never creates a dependence. FP register 0 does create one.
- R8: Independent instructions issue back to back. While `stall_o` is 1 the instruction is held and `issue_o` is 0. Because the remaining-cycle counters keep running through stalls, a run of stalls is never longer than 3 cycles.
- R9: The cycle after a branch issues, `dslot_o` is 1 until the next instruction issues. A branch with ready operands issues at once, and the instruction after it issues at once if it is independent.
- R10: `stall_cnt_o` counts the cycles with `in_valid` 1 and `stall_o` 1, and it saturates. The naive scalar loop (load, add, store, pointer step, branch, empty slot) takes 10 cycles per pass with 4 stalls. The reordered loop takes 6 cycles with 1 stall.
- R11: Only true dependences stall. An overlap between destinations, a source whose use bit is 0, and a store or branch that has its write-enable bit set all cause no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | An instruction is waiting to issue |
| in_cls | input | 3 | Class code of the waiting instruction |
| in_dst_we | input | 1 | Instruction writes a destination register |
| in_dst_fp | input | 1 | Destination is in the FP file |
| in_dst_idx | input | 5 | Destination register index |
| in_sa_use | input | 1 | Source A is read |
| in_sa_fp | input | 1 | Source A is in the FP file |
| in_sa_idx | input | 5 | Source A index |
| in_sb_use | input | 1 | Source B is read |
| in_sb_fp | input | 1 | Source B is in the FP file |
| in_sb_idx | input | 5 | Source B index |
| stall_o | output | 1 | Hold the waiting instruction this cycle |
| issue_o | output | 1 | The waiting instruction issues this cycle |
| dslot_o | output | 1 | The instruction now waiting occupies a branch delay slot |
| stall_cnt_o | output | 16 | Saturating total of stalled cycles |

## Verification
The bench builds the block with its default parameters: a history depth of 4 and a 16-bit stall counter. A depth of 4 is one more than the longest gap in the table, so every pair from the table, every count of intervening instructions, and the expiry of each entry can all be reached. With 16 bits the counter cannot saturate within the run, so the stall totals are compared exactly. The loop timings and the unrolled producer chains check that the counters keep running through stalls, and a reset taken while an FP result is still pending shows that the history really is cleared.

// File: rtl/ilk_pkg.sv
`timescale 1ns/1ps
package ilk_pkg;

  localparam int IDX_W   = 5;
  localparam int LAT_MAX = 3;
  localparam int CNT_W   = $clog2(LAT_MAX + 1);

  typedef enum logic [2:0] {
    C_INT   = 3'd0,
    C_LOAD  = 3'd1,
    C_FPOP  = 3'd2,
    C_STORE = 3'd3,
    C_BR    = 3'd4
  } icls_t;

  typedef struct packed {
    logic             vld;
    logic             fp;
    logic [IDX_W-1:0] idx;
    icls_t            cls;
    logic [CNT_W-1:0] cnt;
  } hent_t;

  // Longest gap any consumer may need from this producer class
  function automatic logic [CNT_W-1:0] cls_span(icls_t c);
    case (c)
      C_FPOP:  cls_span = CNT_W'(3);
      C_LOAD:  cls_span = CNT_W'(1);
      C_INT:   cls_span = CNT_W'(1);
      default: cls_span = '0;
    endcase
  endfunction

  // Required intervening cycles for a producer class and consumer role
  function automatic logic [CNT_W-1:0] pair_gap(icls_t prod, icls_t role);
    case (prod)
      C_FPOP:  pair_gap = (role == C_STORE) ? CNT_W'(2) : CNT_W'(3);
      C_LOAD:  pair_gap = (role == C_STORE) ? CNT_W'(0) : CNT_W'(1);
      C_INT:   pair_gap = (role == C_BR)    ? CNT_W'(1) : CNT_W'(0);
      default: pair_gap = '0;
    endcase
  endfunction

  // One history slot blocks a source when passed cycles fall short
  function automatic logic slot_hit(hent_t e, logic fp, logic [IDX_W-1:0] idx,
                                    icls_t role);
    logic [CNT_W:0] need;
    need = {1'b0, e.cnt} + {1'b0, pair_gap(e.cls, role)};
    slot_hit = e.vld && (e.fp == fp) && (e.idx == idx) &&
               (need > {1'b0, cls_span(e.cls)});
  endfunction

endpackage

// File: rtl/ilk_hist.sv
`timescale 1ns/1ps
module ilk_hist
  import ilk_pkg::*;
#(
  parameter int DEPTH = LAT_MAX + 1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  push,
  input  hent_t new_ent,
  output hent_t ent_o [DEPTH]
);

  hent_t ent_q [DEPTH];
  hent_t ent_d [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    if (g == 0) begin : g_head
      // A stall or an empty cycle shifts in a bubble
      always_comb ent_d[0] = push ? new_ent : '0;
    end else begin : g_tail
      always_comb begin
        ent_d[g]     = ent_q[g-1];
        ent_d[g].vld = ent_q[g-1].vld && (ent_q[g-1].cnt > CNT_W'(1));
        ent_d[g].cnt = (ent_q[g-1].cnt != '0) ? ent_q[g-1].cnt - 1'b1 : '0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ent_q[g] <= '0;
      else        ent_q[g] <= ent_d[g];
    end

    // Counter plus slot age always equals the class span: ticks every cycle
    AST_AGE_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
      ent_q[g].vld |-> (({1'b0, ent_q[g].cnt} + (CNT_W+1)'(g)) ==
                        {1'b0, cls_span(ent_q[g].cls)})); // R8

    assign ent_o[g] = ent_q[g];
  end

  AST_BUBBLE_IN: assert property (@(posedge clk) disable iff (!rst_n)
    !push |=> !ent_q[0].vld); // R8

endmodule

// File: rtl/ilk_match.sv
`timescale 1ns/1ps
module ilk_match
  import ilk_pkg::*;
#(
  parameter int DEPTH = LAT_MAX + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  hent_t            ent_i [DEPTH],
  input  logic             src_use,
  input  logic             src_fp,
  input  logic [IDX_W-1:0] src_idx,
  input  icls_t            role,
  output logic             hit_o
);

  logic [DEPTH-1:0] hv;
  logic             zero_reg;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign hv[g] = slot_hit(ent_i[g], src_fp, src_idx, role);
  end

  assign zero_reg = !src_fp && (src_idx == '0);
  assign hit_o    = src_use && !zero_reg && (|hv);

  AST_ZERO_REG_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_fp && src_idx == '0) |-> !hit_o); // R7

endmodule

// File: rtl/ilk_unit.sv
`timescale 1ns/1ps
module ilk_unit
  import ilk_pkg::*;
#(
  parameter int STALL_CW = 16,
  parameter int HIST_D   = LAT_MAX + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [2:0]          in_cls,
  input  logic                in_dst_we,
  input  logic                in_dst_fp,
  input  logic [IDX_W-1:0]    in_dst_idx,
  input  logic                in_sa_use,
  input  logic                in_sa_fp,
  input  logic [IDX_W-1:0]    in_sa_idx,
  input  logic                in_sb_use,
  input  logic                in_sb_fp,
  input  logic [IDX_W-1:0]    in_sb_idx,
  output logic                stall_o,
  output logic                issue_o,
  output logic                dslot_o,
  output logic [STALL_CW-1:0] stall_cnt_o
);

  localparam int RUN_W = $clog2(LAT_MAX + 2);

  icls_t cls;
  icls_t role_a;
  icls_t role_b;
  logic  hit_a;
  logic  hit_b;
  logic  is_prod;
  logic  push;
  hent_t new_ent;
  hent_t hist [HIST_D];

  logic                dslot_q, dslot_d, dslot_en;
  logic [STALL_CW-1:0] scnt_q, scnt_d;
  logic                scnt_en;

  assign cls = icls_t'(in_cls);

  // Source A of a store is its address, source B its data
  assign role_a = (cls == C_STORE) ? C_INT : cls;
  assign role_b = cls;

  ilk_hist #(.DEPTH(HIST_D)) i_hist (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (push),
    .new_ent (new_ent),
    .ent_o   (hist)
  );

  ilk_match #(.DEPTH(HIST_D)) i_match_a (
    .clk     (clk),
    .rst_n   (rst_n),
    .ent_i   (hist),
    .src_use (in_sa_use),
    .src_fp  (in_sa_fp),
    .src_idx (in_sa_idx),
    .role    (role_a),
    .hit_o   (hit_a)
  );

  ilk_match #(.DEPTH(HIST_D)) i_match_b (
    .clk     (clk),
    .rst_n   (rst_n),
    .ent_i   (hist),
    .src_use (in_sb_use),
    .src_fp  (in_sb_fp),
    .src_idx (in_sb_idx),
    .role    (role_b),
    .hit_o   (hit_b)
  );

  assign stall_o = in_valid && (hit_a || hit_b);
  assign issue_o = in_valid && !stall_o;

  assign is_prod = in_dst_we &&
                   (cls == C_INT || cls == C_LOAD || cls == C_FPOP) &&
                   !(!in_dst_fp && in_dst_idx == '0);
  assign push    = issue_o && is_prod;

  always_comb begin
    new_ent     = '0;
    new_ent.vld = 1'b1;
    new_ent.fp  = in_dst_fp;
    new_ent.idx = in_dst_idx;
    new_ent.cls = cls;
    new_ent.cnt = cls_span(cls);
  end

  // Delay-slot marker: set by a branch issue, cleared by the next issue
  always_comb begin
    dslot_en = issue_o;
    dslot_d  = (cls == C_BR);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        dslot_q <= 1'b0;
    else if (dslot_en) dslot_q <= dslot_d;
  end

  assign dslot_o = dslot_q;

  // Saturating stalled-cycle total
  always_comb begin
    scnt_en = stall_o && (scnt_q != '1);
    scnt_d  = scnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       scnt_q <= '0;
    else if (scnt_en) scnt_q <= scnt_d;
  end

  assign stall_cnt_o = scnt_q;

  // Checker: length of the current run of stalls
  logic [RUN_W-1:0] srun_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       srun_q <= '0;
    else if (stall_o) srun_q <= (srun_q == '1) ? srun_q : srun_q + 1'b1;
    else              srun_q <= '0;
  end

  AST_STALL_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    srun_q <= RUN_W'(LAT_MAX)); // R8
  AST_SLOT_AFTER_BR: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_o && in_cls == 3'd4) |=> dslot_o); // R9
  AST_CNT_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_o && stall_cnt_o != '1) |=> stall_cnt_o == $past(stall_cnt_o) + 1'b1); // R10
  AST_NO_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_o && (in_cls == 3'd3 || in_cls == 3'd4)) |=> !hist[0].vld); // R11

endmodule

// File: tb/test_ilk_unit.sv
`timescale 1ns/1ps
module test_ilk_unit;

  localparam int K_INT = 0, K_LD = 1, K_FP = 2, K_ST = 3, K_BR = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [2:0]  in_cls;
  logic        in_dst_we, in_dst_fp;
  logic [4:0]  in_dst_idx;
  logic        in_sa_use, in_sa_fp;
  logic [4:0]  in_sa_idx;
  logic        in_sb_use, in_sb_fp;
  logic [4:0]  in_sb_idx;
  logic        stall_o, issue_o, dslot_o;
  logic [15:0] stall_cnt_o;

  int total = 0, bad = 0, cyc = 0, tot_stall = 0, last_issue = 0;
  int m_cyc [16];
  int m_idx [16];
  int m_cls [16];
  bit m_fp  [16];
  bit m_prod[16];
  int m_wp = 0;
  bit m_br = 0;

  ilk_unit i_ilk_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cls(in_cls),
    .in_dst_we(in_dst_we), .in_dst_fp(in_dst_fp), .in_dst_idx(in_dst_idx),
    .in_sa_use(in_sa_use), .in_sa_fp(in_sa_fp), .in_sa_idx(in_sa_idx),
    .in_sb_use(in_sb_use), .in_sb_fp(in_sb_fp), .in_sb_idx(in_sb_idx),
    .stall_o(stall_o), .issue_o(issue_o), .dslot_o(dslot_o),
    .stall_cnt_o(stall_cnt_o)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int gap(int p, int r);
    if (p == K_FP) return (r == K_ST) ? 2 : 3;
    if (p == K_LD) return (r == K_ST) ? 0 : 1;
    if (p == K_INT) return (r == K_BR) ? 1 : 0;
    return 0;
  endfunction

  function automatic bit src_blocked(bit u, bit f, int i, int role);
    if (!u || (!f && i == 0)) return 0;
    for (int k = 0; k < 16; k++)
      if (m_prod[k] && m_fp[k] == f && m_idx[k] == i &&
          (cyc - m_cyc[k] - 1) < gap(m_cls[k], role)) return 1;
    return 0;
  endfunction

  task automatic model_clear();
    for (int k = 0; k < 16; k++) m_prod[k] = 0;
    m_br = 0;
    tot_stall = 0;
  endtask

  task automatic idle(input int n);
    in_valid = 0;
    repeat (n) @(negedge clk);
  endtask

  // Drive one instruction until it issues; ns returns its stall cycles
  task automatic run_instr(input int c, input bit we, input bit dfp, input int di,
                           input bit u1, input bit f1, input int i1,
                           input bit u2, input bit f2, input int i2,
                           output int ns);
    bit exp;
    ns = 0;
    in_valid = 1; in_cls = 3'(c); in_dst_we = we; in_dst_fp = dfp;
    in_dst_idx = 5'(di); in_sa_use = u1; in_sa_fp = f1; in_sa_idx = 5'(i1);
    in_sb_use = u2; in_sb_fp = f2; in_sb_idx = 5'(i2);
    forever begin
      #1;
      exp = src_blocked(u1, f1, i1, (c == K_ST) ? K_INT : c) ||
            src_blocked(u2, f2, i2, c);
      chk(stall_o === exp, "R8 stall vs table", int'(stall_o), int'(exp));
      chk(dslot_o === m_br, "R9 delay-slot flag", int'(dslot_o), int'(m_br));
      if (!stall_o) begin
        chk(issue_o === 1'b1, "R8 issue", int'(issue_o), 1);
        m_cyc[m_wp] = cyc; m_fp[m_wp] = dfp; m_idx[m_wp] = di; m_cls[m_wp] = c;
        m_prod[m_wp] = we && (c <= K_FP) && !(!dfp && di == 0);
        m_wp = (m_wp + 1) % 16;
        m_br = (c == K_BR);
        last_issue = cyc;
        @(negedge clk);
        break;
      end
      chk(issue_o === 1'b0, "R8 held while stalled", int'(issue_o), 0);
      ns++; tot_stall++;
      @(negedge clk);
      if (ns > 8) begin
        chk(0, "R8 stall never ends", ns, 3);
        break;
      end
    end
  endtask

  task automatic nop(); int s; run_instr(K_INT, 0,0,0, 0,0,0, 0,0,0, s); endtask

  task automatic do_reset();
    @(negedge clk);
    in_valid = 0;
    rst_n = 0;
    repeat (2) @(negedge clk);
    model_clear();
    #1;
    chk(stall_o === 1'b0, "R1 stall in reset", int'(stall_o), 0);
    chk(dslot_o === 1'b0, "R1 dslot in reset", int'(dslot_o), 0);
    chk(stall_cnt_o === 16'd0, "R1 count in reset", int'(stall_cnt_o), 0);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    chk(0, "R8 watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int s, st0, c0;
    void'($urandom(32'h5eed_1c3a));
    rst_n = 0; in_valid = 0; in_cls = 0; in_dst_we = 0; in_dst_fp = 0;
    in_dst_idx = 0; in_sa_use = 0; in_sa_fp = 0; in_sa_idx = 0;
    in_sb_use = 0; in_sb_fp = 0; in_sb_idx = 0;
    model_clear();
    do_reset();

    // R2: FP->FP needs three, intervening issue counts
    run_instr(K_FP, 1,1,4, 1,1,0, 1,1,2, s);
    run_instr(K_FP, 1,1,6, 1,1,4, 1,1,2, s); chk(s == 3, "R2 fp->fp", s, 3);
    idle(4);
    run_instr(K_FP, 1,1,4, 1,1,0, 1,1,2, s);
    nop();
    run_instr(K_FP, 1,1,6, 1,1,2, 1,1,4, s); chk(s == 2, "R2 fp->fp after one", s, 2);
    idle(4);
    // R3: FP -> store data
    run_instr(K_FP, 1,1,8, 1,1,0, 1,1,2, s);
    run_instr(K_ST, 0,0,0, 1,0,1, 1,1,8, s); chk(s == 2, "R3 fp->store", s, 2);
    idle(4);
    // R4 / R5: load -> FP, load -> store data
    run_instr(K_LD, 1,1,10, 1,0,1, 0,0,0, s);
    run_instr(K_FP, 1,1,11, 1,1,10, 1,1,2, s); chk(s == 1, "R4 load->fp", s, 1);
    run_instr(K_LD, 1,1,12, 1,0,1, 0,0,0, s);
    run_instr(K_ST, 0,0,0, 1,0,1, 1,1,12, s); chk(s == 0, "R5 load->store", s, 0);
    idle(4);
    // R6: integer producer towards branch, integer op, store address
    run_instr(K_INT, 1,0,3, 1,0,1, 0,0,0, s);
    run_instr(K_BR, 0,0,0, 1,0,3, 1,0,2, s); chk(s == 1, "R6 int->branch", s, 1);
    run_instr(K_INT, 1,0,4, 1,0,1, 0,0,0, s);
    run_instr(K_INT, 1,0,5, 1,0,4, 0,0,0, s); chk(s == 0, "R6 int->int", s, 0);
    run_instr(K_ST, 0,0,0, 1,0,5, 1,1,9, s); chk(s == 0, "R6 int->store addr", s, 0);
    idle(4);
    // R7: integer r0, file separation, FP register 0
    run_instr(K_INT, 1,0,0, 1,0,1, 0,0,0, s);
    run_instr(K_BR, 0,0,0, 1,0,0, 0,0,0, s); chk(s == 0, "R7 int r0", s, 0);
    run_instr(K_FP, 1,1,3, 1,1,1, 0,0,0, s);
    run_instr(K_BR, 0,0,0, 1,0,3, 0,0,0, s); chk(s == 0, "R7 file bit", s, 0);
    run_instr(K_LD, 1,1,0, 1,0,1, 0,0,0, s);
    run_instr(K_FP, 1,1,1, 1,1,0, 0,0,0, s); chk(s == 1, "R7 fp reg0", s, 1);
    idle(4);
    // R11: WAW, unused source, store/branch with write enable
    run_instr(K_FP, 1,1,5, 1,1,1, 0,0,0, s);
    run_instr(K_FP, 1,1,5, 1,1,1, 0,0,0, s); chk(s == 0, "R11 waw", s, 0);
    run_instr(K_FP, 1,1,6, 0,1,5, 0,1,5, s); chk(s == 0, "R11 unused src", s, 0);
    idle(4);
    run_instr(K_ST, 1,0,7, 1,0,1, 1,1,9, s);
    run_instr(K_BR, 1,0,7, 1,0,7, 0,0,0, s); chk(s == 0, "R11 store we", s, 0);
    run_instr(K_BR, 0,0,0, 1,0,7, 0,0,0, s); chk(s == 0, "R11 branch we", s, 0);
    // R9: branch costs nothing extra, slot flag after it
    run_instr(K_INT, 1,0,9, 1,0,8, 0,0,0, s);
    chk(dslot_o === 1'b0, "R9 flag cleared", int'(dslot_o), 0);
    run_instr(K_BR, 0,0,0, 1,0,8, 0,0,0, s); chk(s == 0, "R9 branch free", s, 0);
    #1 chk(dslot_o === 1'b1, "R9 slot flagged", int'(dslot_o), 1);
    run_instr(K_INT, 1,0,10, 1,0,8, 0,0,0, s); chk(s == 0, "R9 slot issues", s, 0);
    idle(4);
    #1 chk(stall_cnt_o == 16'(tot_stall), "R10 total", int'(stall_cnt_o), tot_stall);
    @(negedge clk);

    // R10: naive loop, three passes
    st0 = tot_stall; c0 = cyc;
    for (int it = 0; it < 3; it++) begin
      run_instr(K_LD, 1,1,0, 1,0,1, 0,0,0, s);
      run_instr(K_FP, 1,1,4, 1,1,0, 1,1,2, s);
      run_instr(K_ST, 0,0,0, 1,0,1, 1,1,4, s);
      run_instr(K_INT, 1,0,1, 1,0,1, 0,0,0, s);
      run_instr(K_BR, 0,0,0, 1,0,1, 1,0,2, s);
      nop();
    end
    chk(last_issue - c0 + 1 == 30, "R10 naive cycles", last_issue - c0 + 1, 30);
    chk(tot_stall - st0 == 12, "R10 naive stalls", tot_stall - st0, 12);
    idle(4);
    // R10: reordered loop
    st0 = tot_stall; c0 = cyc;
    for (int it = 0; it < 3; it++) begin
      run_instr(K_LD, 1,1,0, 1,0,1, 0,0,0, s);
      run_instr(K_INT, 1,0,1, 1,0,1, 0,0,0, s);
      run_instr(K_FP, 1,1,4, 1,1,0, 1,1,2, s);
      run_instr(K_BR, 0,0,0, 1,0,1, 1,0,2, s);
      run_instr(K_ST, 0,0,0, 1,0,1, 1,1,4, s);
    end
    chk(last_issue - c0 + 1 == 18, "R10 reordered cycles", last_issue - c0 + 1, 18);
    chk(tot_stall - st0 == 3, "R10 reordered stalls", tot_stall - st0, 3);
    #1 chk(stall_cnt_o == 16'(tot_stall), "R10 total", int'(stall_cnt_o), tot_stall);
    @(negedge clk);

    // R1: reset drops a pending FP producer
    run_instr(K_FP, 1,1,4, 1,1,0, 1,1,2, s);
    do_reset();
    run_instr(K_FP, 1,1,6, 1,1,4, 0,0,0, s); chk(s == 0, "R1 history cleared", s, 0);

    // R8: random mix against the table model
    for (int n = 0; n < 500; n++) begin
      int c;
      c = $urandom_range(0, 4);
      run_instr(c, $urandom_range(0,1), $urandom_range(0,1), $urandom_range(0,3),
                $urandom_range(0,1), $urandom_range(0,1), $urandom_range(0,3),
                $urandom_range(0,1), $urandom_range(0,1), $urandom_range(0,3), s);
      if ($urandom_range(0, 7) == 0) idle(1);
    end
    #1 chk(stall_cnt_o == 16'(tot_stall), "R10 random total", int'(stall_cnt_o), tot_stall);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule